// File: doc/BRIEF.md
# SPI Daisy-Chain Segment Handler

This block is the serial front end of one I/O expander that sits in a ring of identical devices. The controller's serial output feeds the first device. Each device's serial output feeds the next device's input, and the last device's output returns to the controller. Traffic is made of 16-bit segments, sent most significant bit first. A 16-bit shift stage inside each device delays every segment by exactly one segment slot before passing it on. At the start of a transaction the device places its own word in that stage: either a status word holding fault bits, or the byte left by an earlier read.

The controller sends one header word carrying the chain length N. It then sends N address words and N data words, each group ordered with the farthest device first. Each device finds its own slot without being told its position. It counts completed segments from the moment chip select falls. Its address word is always segment N and its data word is always segment 2N, the word still held in the stage when chip select rises. At the end of the frame the device checks that the frame is consistent. If it is, the device issues one request on a plain register-file port. All serial inputs are treated as already synchronous to the system clock, and SCLK edges are found by comparing samples.

Top module: `spi_chain_seg`

## Requirements
- R1: While rst_ni is low, sdo_o is 0 and reg_req_o is 0.
- R2: While cs_ni is high (after its first sampled cycle high), sdo_o is 0.
- R3: Each bit sampled on sdi_i at a rising SCLK edge reappears on sdo_o 16 SCLK periods later. Word j+1 shifted out therefore equals word j shifted in.
- R4: Unless a read result is pending, the first word sent in a transaction is a status word. Its bits are: [15:14]=11, [13] framing-error flag, [12:8]=ext_fault_i sampled at chip-select fall, [7:0]=0.
- R5: The first completed segment whose bits [15:14]=01 is taken as the header. Its bits [4:0] give N and its bits [13:5] are ignored. Upstream words with [15:14]=11 or 00 are never taken as the header.
- R6: Counting completed segments from 0 at chip-select fall, segment N is this device's address word and segment 2N is its data word. The address word has bit 15 = read and bits [14:8] = register address; in the data word, bits [7:0] are the write data.
- R7: At chip-select rise with a valid frame, reg_req_o pulses for exactly one cycle, one cycle after cs_ni is first sampled high. During that pulse, reg_we_o = NOT the read bit, reg_addr_o = the address field and reg_wdata_o = data bits [7:0].
- R8: A frame is invalid if any of these holds: no header was seen, N=0, the header arrived at segment index N or later, or the SCLK count differs from 16×(1+2N). An invalid frame issues no request and sets the framing-error flag. The next valid frame clears the flag.
- R9: A read request samples reg_rdata_i in the pulse cycle. The next transaction sends {8'h00, byte} as its first word instead of the status word, only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| cs_ni | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in from upstream |
| sdo_o | output | 1 | Serial data out to downstream |
| ext_fault_i | input | 5 | Fault bits placed in the status word |
| reg_req_o | output | 1 | One-cycle register access request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 7 | Register address |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data, valid during reg_req_o |

## Verification
Some properties are checked on every cycle. sdo_o may change only after a falling SCLK edge or a chip-select edge, and it stays low while chip select is idle. A request is a single pulse that follows a chip-select rise and never coincides with a set framing flag. A pending read byte is created only by a read request. Other behaviour can only be shown by the bench's chain scenarios: slot finding at every position, including the 31-device limit; exact pass-through contents; header selection past upstream words; and rejection of truncated, overlong, zero-length and out-of-range frames. Those scenarios model the controller and upstream devices bit by bit.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int SEG_W     = 16;
  localparam int ID_W      = 2;
  localparam int MAX_DEV   = 31;
  localparam int NDEV_W    = $clog2(MAX_DEV + 1);
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int CMD_W     = SEG_W - DATA_W;          // read bit + address
  localparam int FLT_W     = SEG_W - ID_W - DATA_W;   // framing + external
  localparam int EXT_FLT_W = FLT_W - 1;
  localparam int SEG_LOG   = $clog2(SEG_W);
  localparam int CNT_W     = $clog2((2 * MAX_DEV + 1) * SEG_W + 1);
  localparam int IDX_W     = CNT_W - SEG_LOG;

  typedef enum logic [ID_W-1:0] {
    SEG_DATA = 2'b00,
    SEG_HDR  = 2'b01,
    SEG_RSVD = 2'b10,
    SEG_STS  = 2'b11
  } seg_kind_e;
endpackage

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter #(
  parameter int SEG_BITS = 16,
  parameter int CNT_BITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                cs_ni,
  input  logic                sdi_i,
  input  logic [SEG_BITS-1:0] preload_i,
  output logic                sdo_o,
  output logic                cs_fall_o,
  output logic                cs_rise_o,
  output logic                seg_done_o,
  output logic [SEG_BITS-1:0] seg_word_o,
  output logic [CNT_BITS-SEG_LOG_L-1:0] seg_idx_o,
  output logic [CNT_BITS-1:0] bit_cnt_o,
  output logic [SEG_BITS-1:0] shreg_o
);
  localparam int SEG_LOG_L = $clog2(SEG_BITS);

  logic                sclk_q, cs_q, sdo_q;
  logic [SEG_BITS-1:0] shreg_q;
  logic [CNT_BITS-1:0] cnt_q;
  logic                sclk_rise, sclk_fall, cnt_sat;

  assign cs_fall_o  = cs_q & ~cs_ni;
  assign cs_rise_o  = ~cs_q & cs_ni;
  assign sclk_rise  = sclk_i & ~sclk_q & ~cs_ni;
  assign sclk_fall  = ~sclk_i & sclk_q & ~cs_ni;
  assign cnt_sat    = &cnt_q;
  assign seg_done_o = sclk_rise & ~cs_fall_o & ~cnt_sat & (&cnt_q[SEG_LOG_L-1:0]);
  assign seg_word_o = {shreg_q[SEG_BITS-2:0], sdi_i};
  assign seg_idx_o  = cnt_q[CNT_BITS-1:SEG_LOG_L];
  assign bit_cnt_o  = cnt_q;
  assign shreg_o    = shreg_q;
  assign sdo_o      = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
      sdo_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (cs_fall_o) begin
        shreg_q <= preload_i;
        cnt_q   <= '0;
      end else if (sclk_rise) begin
        shreg_q <= {shreg_q[SEG_BITS-2:0], sdi_i};
        if (!cnt_sat) cnt_q <= cnt_q + 1'b1;
      end
      if (cs_ni)          sdo_q <= 1'b0;
      else if (cs_fall_o) sdo_q <= preload_i[SEG_BITS-1];
      else if (sclk_fall) sdo_q <= shreg_q[SEG_BITS-1];
    end
  end
endmodule

// File: rtl/spi_chain_tracker.sv
module spi_chain_tracker import spi_chain_pkg::*; #(
  parameter int SEG_BITS  = 16,
  parameter int IDX_BITS  = 6,
  parameter int NDEV_BITS = 5,
  parameter int CMD_BITS  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_fall_i,
  input  logic                 seg_done_i,
  input  logic [SEG_BITS-1:0]  seg_word_i,
  input  logic [IDX_BITS-1:0]  seg_idx_i,
  output logic                 hdr_seen_o,
  output logic [NDEV_BITS-1:0] n_dev_o,
  output logic [IDX_BITS-1:0]  hdr_seg_o,
  output logic [CMD_BITS-1:0]  cmd_o
);
  seg_kind_e kind;
  logic      own_addr;
  logic      unused_mid;

  assign kind       = seg_kind_e'(seg_word_i[SEG_BITS-1 -: ID_W]);
  assign own_addr   = hdr_seen_o && (seg_idx_i == IDX_BITS'(n_dev_o));
  assign unused_mid = ^seg_word_i[SEG_BITS-CMD_BITS-1:NDEV_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_seen_o <= 1'b0;
      n_dev_o    <= '0;
      hdr_seg_o  <= '0;
      cmd_o      <= '0;
    end else if (cs_fall_i) begin
      hdr_seen_o <= 1'b0;
      n_dev_o    <= '0;
      hdr_seg_o  <= '0;
      cmd_o      <= '0;
    end else if (seg_done_i) begin
      if (!hdr_seen_o && kind == SEG_HDR) begin
        hdr_seen_o <= 1'b1;
        n_dev_o    <= seg_word_i[NDEV_BITS-1:0];
        hdr_seg_o  <= seg_idx_i;
      end else if (own_addr) begin
        cmd_o <= seg_word_i[SEG_BITS-1 -: CMD_BITS];
      end
    end
  end
endmodule

// File: rtl/spi_chain_cmd.sv
module spi_chain_cmd import spi_chain_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_fall_i,
  input  logic                 cs_rise_i,
  input  logic                 frame_ok_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [EXT_FLT_W-1:0] ext_fault_i,
  input  logic [DATA_W-1:0]    reg_rdata_i,
  output logic                 reg_req_o,
  output logic                 reg_we_o,
  output logic [ADDR_W-1:0]    reg_addr_o,
  output logic [DATA_W-1:0]    reg_wdata_o,
  output logic                 frame_err_o,
  output logic                 rd_pend_o,
  output logic [SEG_W-1:0]     preload_o
);
  logic [DATA_W-1:0] rd_byte_q;

  assign preload_o = rd_pend_o ? {{(SEG_W-DATA_W){1'b0}}, rd_byte_q}
                               : {SEG_STS, frame_err_o, ext_fault_i, {DATA_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_req_o   <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      frame_err_o <= 1'b0;
      rd_pend_o   <= 1'b0;
      rd_byte_q   <= '0;
    end else begin
      reg_req_o <= 1'b0;
      if (cs_rise_i) begin
        reg_req_o   <= frame_ok_i;
        reg_we_o    <= ~cmd_i[CMD_W-1];
        reg_addr_o  <= cmd_i[ADDR_W-1:0];
        reg_wdata_o <= wdata_i;
        frame_err_o <= ~frame_ok_i;
      end
      if (cs_fall_i) begin
        rd_pend_o <= 1'b0;
      end else if (reg_req_o && !reg_we_o) begin
        rd_pend_o <= 1'b1;
        rd_byte_q <= reg_rdata_i;
      end
    end
  end
endmodule

// File: rtl/spi_chain_seg.sv
module spi_chain_seg import spi_chain_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 cs_ni,
  input  logic                 sdi_i,
  output logic                 sdo_o,
  input  logic [EXT_FLT_W-1:0] ext_fault_i,
  output logic                 reg_req_o,
  output logic                 reg_we_o,
  output logic [ADDR_W-1:0]    reg_addr_o,
  output logic [DATA_W-1:0]    reg_wdata_o,
  input  logic [DATA_W-1:0]    reg_rdata_i
);
  logic              cs_fall, cs_rise, seg_done, hdr_seen, frame_ok;
  logic              frame_err, rd_pend;
  logic [SEG_W-1:0]  seg_word, shreg, preload;
  logic [IDX_W-1:0]  seg_idx, hdr_seg;
  logic [CNT_W-1:0]  bit_cnt, exp_bits;
  logic [NDEV_W-1:0] n_dev;
  logic [CMD_W-1:0]  cmd;
  logic              unused_hi;

  spi_chain_shifter #(.SEG_BITS(SEG_W), .CNT_BITS(CNT_W)) u_shift (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .sdi_i,
    .preload_i (preload),
    .sdo_o,
    .cs_fall_o (cs_fall),
    .cs_rise_o (cs_rise),
    .seg_done_o(seg_done),
    .seg_word_o(seg_word),
    .seg_idx_o (seg_idx),
    .bit_cnt_o (bit_cnt),
    .shreg_o   (shreg)
  );

  spi_chain_tracker #(
    .SEG_BITS(SEG_W), .IDX_BITS(IDX_W), .NDEV_BITS(NDEV_W), .CMD_BITS(CMD_W)
  ) u_track (
    .clk_i, .rst_ni,
    .cs_fall_i (cs_fall),
    .seg_done_i(seg_done),
    .seg_word_i(seg_word),
    .seg_idx_i (seg_idx),
    .hdr_seen_o(hdr_seen),
    .n_dev_o   (n_dev),
    .hdr_seg_o (hdr_seg),
    .cmd_o     (cmd)
  );

  // frame holds header + N addresses + N data words
  assign exp_bits  = (CNT_W'(n_dev) * CNT_W'(2) + CNT_W'(1)) << SEG_LOG;
  assign frame_ok  = hdr_seen && (n_dev != '0) && (hdr_seg < IDX_W'(n_dev))
                     && (bit_cnt == exp_bits);
  assign unused_hi = ^shreg[SEG_W-1:DATA_W];

  spi_chain_cmd u_cmd (
    .clk_i, .rst_ni,
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .frame_ok_i (frame_ok),
    .cmd_i      (cmd),
    .wdata_i    (shreg[DATA_W-1:0]),
    .ext_fault_i,
    .reg_rdata_i,
    .reg_req_o, .reg_we_o, .reg_addr_o, .reg_wdata_o,
    .frame_err_o(frame_err),
    .rd_pend_o  (rd_pend),
    .preload_o  (preload)
  );
endmodule

// File: rtl/spi_chain_seg_chk.sv
module spi_chain_seg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sclk_i,
  input logic sdo_o,
  input logic reg_req_o,
  input logic reg_we_o,
  input logic frame_err_i,
  input logic rd_pend_i
);
  assert_sdo_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) |-> !sdo_o);

  assert_sdo_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> (!$past(sclk_i) && $past(sclk_i, 2)) || ($past(cs_ni) != $past(cs_ni, 2)));

  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |=> !reg_req_o);

  assert_req_after_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> $past(cs_ni) && !$past(cs_ni, 2));

  assert_req_no_ferr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> !frame_err_i);

  assert_rd_pend_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_pend_i) |-> $past(reg_req_o && !reg_we_o));
endmodule

bind spi_chain_seg spi_chain_seg_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sclk_i     (sclk_i),
  .sdo_o      (sdo_o),
  .reg_req_o  (reg_req_o),
  .reg_we_o   (reg_we_o),
  .frame_err_i(frame_err),
  .rd_pend_i  (rd_pend)
);

// File: tb/spi_chain_seg_tb_top.sv
module spi_chain_seg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, sclk, cs_n, sdi;
  logic       sdo, req, we;
  logic [4:0] ext_fault;
  logic [6:0] raddr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [128];

  always #4 clk = ~clk;  // 125 MHz

  spi_chain_seg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .ext_fault_i(ext_fault), .reg_req_o(req), .reg_we_o(we),
    .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  assign rdata = mem[raddr];

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] stream [0:79];
  logic [15:0] rx [0:79];
  bit         m_rd_pend;
  logic [7:0] m_rd_byte;
  bit         m_ferr;
  int         req_cnt;
  logic       req_we;
  logic [6:0] req_addr;
  logic [7:0] req_wdata;

  // register-file stub and request monitor
  always @(negedge clk) begin
    if (rst_n && req) begin
      req_cnt++;
      req_we = we;
      req_addr = raddr;
      req_wdata = wdata;
      if (we) mem[raddr] = wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pre();
    return m_rd_pend ? {8'h00, m_rd_byte} : {2'b11, m_ferr, ext_fault, 8'h00};
  endfunction

  task automatic build(input int n, input int k, input int nhdr, input bit rd,
                       input logic [6:0] a, input logic [7:0] d);
    logic [15:0] ctrl [0:79];
    for (int i = 0; i < 80; i++) ctrl[i] = 16'($urandom);
    ctrl[0] = {2'b01, 9'($urandom), 5'(nhdr)};
    if (k >= 1 && k <= n) begin
      ctrl[n + 1 - k]     = {rd, a, 8'($urandom)};
      ctrl[2 * n + 1 - k] = {8'($urandom), d};
    end
    for (int j = 0; j < 80; j++) begin
      if (j < k - 1) stream[j] = ($urandom % 2) ? {2'b11, 6'($urandom), 8'h00} : {8'h00, 8'($urandom)};
      else           stream[j] = ctrl[j - (k - 1)];
    end
  endtask

  task automatic xfer(input int nbits);
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      sdi = stream[b / 16][15 - b % 16];
      repeat (3) @(negedge clk);
      rx[b / 16][15 - b % 16] = sdo;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input bit ok, input bit rd,
                       input logic [6:0] a, input logic [7:0] d);
    logic [15:0] pre;
    string       ptag;
    int          bad = 0;
    int          first = 0;
    ext_fault = 5'($urandom);
    pre  = exp_pre();
    ptag = m_rd_pend ? "R9" : "R4";
    m_rd_pend = 0;
    req_cnt = 0;
    xfer(nbits);
    if (nbits >= 16) chk(rx[0] == pre, ptag, rx[0], pre);
    for (int j = 1; j < nbits / 16; j++)
      if (rx[j] != stream[j - 1]) begin
        if (bad == 0) first = j;
        bad++;
      end
    chk(bad == 0, "R3", rx[first], stream[first == 0 ? 0 : first - 1]);
    chk(sdo == 1'b0, "R2", sdo, 0);
    if (ok) begin
      chk(req_cnt == 1, "R5", req_cnt, 1);
      chk(req_we == !rd, "R7", req_we, !rd);
      chk(req_addr == a, "R6", req_addr, a);
      if (!rd) chk(req_wdata == d, "R6", req_wdata, d);
      m_ferr = 0;
      if (rd) begin
        m_rd_pend = 1;
        m_rd_byte = mem[a];
      end
    end else begin
      chk(req_cnt == 0, "R8", req_cnt, 0);
      m_ferr = 1;
    end
  endtask

  task automatic good(input int n, input int k, input bit rd);
    logic [6:0] a = 7'($urandom);
    logic [7:0] d = 8'($urandom);
    build(n, k, n, rd, a, d);
    frame(16 * (1 + 2 * n), 1, rd, a, d);
  endtask

  initial begin
    void'($urandom(32'd20250));
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 29 + 7) ^ 8'h5a);
    rst_n = 0; sclk = 0; cs_n = 1; sdi = 0; ext_fault = 0;
    m_rd_pend = 0; m_rd_byte = 0; m_ferr = 0;
    repeat (5) @(negedge clk);
    chk(sdo == 1'b0 && req == 1'b0, "R1", {sdo, req}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0, "R2", sdo, 0);

    good(1, 1, 0);                       // minimum chain
    good(3, 2, 1);                       // read, middle slot
    good(31, 31, 0);                     // maximum chain, farthest; returns read byte
    good(31, 1, 1);                      // maximum chain, nearest
    build(4, 3, 4, 0, 7'h11, 8'h22);
    frame(16 * 9 - 1, 0, 0, 0, 0);       // R8: one bit short
    good(2, 2, 0);                       // R8: flag visible then cleared
    build(0, 1, 0, 0, 0, 0);
    frame(16, 0, 0, 0, 0);               // R8: zero-length chain
    build(2, 1, 2, 0, 7'h33, 8'h44);
    frame(16 * 6, 0, 0, 0, 0);           // R8: extra word
    build(2, 3, 2, 0, 0, 0);
    frame(16 * 5, 0, 0, 0, 0);           // R8: device beyond chain length
    good(2, 1, 1);
    for (int t = 0; t < 16; t++) begin
      int n = 1 + $urandom % 8;
      good(n, 1 + $urandom % n, 1'($urandom));
    end
    good(1, 1, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule